// File: doc/BRIEF.md
# Audio Subframe Formatter with Channel Status

This block sits in front of an HDMI audio packetizer and rewrites a stream of 32-bit audio words into the subframe layout the packetizer consumes. Each accepted input word yields exactly one output word. Words arrive on a valid/ready stream as interleaved frames, and each frame carries one word per channel. The channel count runs from 2 to 8.

There are two input modes. In subframe mode the source already supplies complete subframes. The flag nibble sits at the top, audio sits in the middle and a preamble code sits in the low nibble. The block moves these fields down into the packetizer layout. In PCM mode the source supplies plain 24-bit samples. The block then discards the top byte and builds it itself. It adds a channel-status bit taken from a 192-frame block sequence, a block-start marker and an even-parity bit. A host writes the four consumer channel-status bytes through a small write port. The block replaces the channel-number nibble of byte 2 with each channel's own number.

A synchronous clear returns the channel and frame position to the start of a block. It is issued whenever a new stream begins. Mode and channel count are taken only while the stream is idle.

Top module: `aud_subframe_fmt`

## Requirements
- R1: In subframe mode (mode_pcm=0) the output word is {3'b000, in[3], in[31:4]}. The flag nibble from bits 31..28 moves to bits 27..24, the audio from bits 27..4 moves to bits 23..0, and bit 28 copies the block-start preamble bit in[3] (preamble codes are 8 = block start, 4 = even, 2 = odd).
- R2: In PCM mode (mode_pcm=1) output bits 23..0 equal input bits 23..0, input bits 31..24 have no effect, and output bits 31..29, 25 and 24 are 0.
- R3: In PCM mode, for frame index n < 32 the output bit 26 is bit (n mod 8) of channel-status byte (n div 8). For n from 32 to 191 bit 26 is 0.
- R4: For frames 20..23, output bit 26 instead carries bit (n-20) of the value channel index + 1, so the status nibble in byte 2, bits 7..4, names each channel.
- R5: In PCM mode output bit 28 is 1 only on channel 0 of frame 0.
- R6: In PCM mode output bit 27 is the XOR of output bits 26..0, so bits 27..0 have even parity.
- R7: The frame index advances once after the last channel of a frame and wraps from 191 to 0.
- R8: chan_cnt sets the number of interleaved channels. A value below 2 acts as 2 and a value above 8 acts as 8.
- R9: While clr is high, in_ready is 0. One cycle after clr, the channel and frame indices are both 0.
- R10: mode_pcm and chan_cnt are sampled only on a cycle where no word is accepted and the channel index is 0. A change made mid-frame takes effect at the next such idle point.
- R11: in_ready = !clr && (!out_valid || out_ready). While out_valid is high and out_ready is low, out_valid and out_data hold.
- R12: A host write with cs_wr_en stores cs_wr_data into status byte cs_wr_addr (0..3). All status bytes are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous restart of channel/frame position |
| mode_pcm | input | 1 | 1 = PCM with generated status, 0 = subframe repack |
| chan_cnt | input | 4 | Channels per frame (clamped to 2..8) |
| cs_wr_en | input | 1 | Host write strobe for status bytes |
| cs_wr_addr | input | 2 | Status byte select |
| cs_wr_data | input | 8 | Status byte value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input audio word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Formatted subframe word |

## Verification
The assertions check on every cycle the rules that hold without any knowledge of the stream history. These are the even parity and zero fields of every PCM output, that output holds under backpressure, that the channel index stays in range, that the frame index wraps after 191, that clear returns the indices to 0, and that the configuration does not change mid-frame. The rest needs the bench's reference model, which tracks the position in the block. This covers which frame carries which status bit, the channel-number substitution in frames 20..23, the single block-start marker, the clamping of the channel count, and the point at which a mid-frame mode change takes effect.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

    localparam int WORD_W  = 32;
    localparam int AUD_W   = 24;
    localparam int BIT_BLK = 28;   // block-start marker
    localparam int BIT_PAR = 27;   // even parity over 26..0
    localparam int BIT_C   = 26;   // channel-status bit

    typedef logic [WORD_W-1:0] word_t;

    // Subframe mode: flags down by four, preamble bit 3 becomes block start
    function automatic word_t repack_subframe(input word_t w);
        return {3'b000, w[3], w[WORD_W-1:4]};
    endfunction

endpackage

// File: rtl/aud_cs_regfile.sv
module aud_cs_regfile #(
    parameter  int CS_BYTES = 4,
    localparam int ADDR_W   = $clog2(CS_BYTES),
    localparam int CS_BITS  = CS_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic [CS_BITS-1:0] cs_flat
);

    for (genvar b = 0; b < CS_BYTES; b++) begin : g_byte
        logic [7:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (wr_en && (wr_addr == ADDR_W'(b)))
                byte_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end

        assign cs_flat[b*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/aud_seq_counter.sv
module aud_seq_counter #(
    parameter  int MAX_CH    = 8,
    parameter  int BLOCK_LEN = 192,
    localparam int CNT_W     = $clog2(MAX_CH + 1),
    localparam int CH_W      = $clog2(MAX_CH),
    localparam int FR_W      = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] ch_count,
    output logic [CH_W-1:0]  ch_idx,
    output logic [FR_W-1:0]  frame_idx
);

    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic [FR_W-1:0] fr;
    } pos_t;

    pos_t pos_d, pos_q;
    logic last_ch;

    always_comb begin
        pos_d   = pos_q;
        last_ch = (CNT_W'(pos_q.ch) + CNT_W'(1)) >= ch_count;
        if (clr) begin
            pos_d = '0;
        end else if (step) begin
            if (last_ch) begin
                pos_d.ch = '0;
                if (pos_q.fr == FR_W'(BLOCK_LEN - 1))
                    pos_d.fr = '0;
                else
                    pos_d.fr = pos_q.fr + FR_W'(1);
            end else begin
                pos_d.ch = pos_q.ch + CH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign ch_idx    = pos_q.ch;
    assign frame_idx = pos_q.fr;

    AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(ch_idx) < ch_count);                                        // R8

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && last_ch && frame_idx == FR_W'(BLOCK_LEN - 1))
        |=> (frame_idx == '0));                                            // R7

    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx < FR_W'(BLOCK_LEN));                                     // R7

    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ch_idx == '0 && frame_idx == '0));                        // R9

endmodule

// File: rtl/aud_subframe_packer.sv
module aud_subframe_packer
    import aud_fmt_pkg::*;
#(
    parameter  int MAX_CH     = 8,
    parameter  int BLOCK_LEN  = 192,
    parameter  int CS_BYTES   = 4,
    parameter  int CHNUM_BYTE = 2,
    parameter  int CHNUM_LSB  = 4,
    localparam int CH_W       = $clog2(MAX_CH),
    localparam int FR_W       = $clog2(BLOCK_LEN),
    localparam int CS_BITS    = CS_BYTES * 8,
    localparam int CSI_W      = $clog2(CS_BITS),
    localparam int CHNUM_W    = 4,
    localparam int CHNUM_POS  = CHNUM_BYTE * 8 + CHNUM_LSB
) (
    input  logic               pcm,
    input  word_t              in_word,
    input  logic [CH_W-1:0]    ch_idx,
    input  logic [FR_W-1:0]    frame_idx,
    input  logic [CS_BITS-1:0] cs_flat,
    output word_t              out_word
);

    logic [CS_BITS-1:0] cs_chan;
    logic               c_bit;
    logic               blk;
    word_t              pcm_word;

    always_comb begin
        cs_chan = cs_flat;
        cs_chan[CHNUM_POS +: CHNUM_W] = CHNUM_W'(ch_idx) + CHNUM_W'(1);
        if (frame_idx < FR_W'(CS_BITS))
            c_bit = cs_chan[frame_idx[CSI_W-1:0]];
        else
            c_bit = 1'b0;
        blk = (ch_idx == '0) && (frame_idx == '0);

        pcm_word              = '0;
        pcm_word[AUD_W-1:0]   = in_word[AUD_W-1:0];
        pcm_word[BIT_C]       = c_bit;
        pcm_word[BIT_BLK]     = blk;
        pcm_word[BIT_PAR]     = ^pcm_word[BIT_C:0];

        out_word = pcm ? pcm_word : repack_subframe(in_word);
    end

endmodule

// File: rtl/aud_subframe_fmt.sv
module aud_subframe_fmt
    import aud_fmt_pkg::*;
#(
    parameter  int MAX_CH    = 8,
    parameter  int MIN_CH    = 2,
    parameter  int BLOCK_LEN = 192,
    parameter  int CS_BYTES  = 4,
    localparam int CNT_W     = $clog2(MAX_CH + 1),
    localparam int CH_W      = $clog2(MAX_CH),
    localparam int FR_W      = $clog2(BLOCK_LEN),
    localparam int CSA_W     = $clog2(CS_BYTES),
    localparam int CS_BITS   = CS_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mode_pcm,
    input  logic [CNT_W-1:0]  chan_cnt,
    input  logic              cs_wr_en,
    input  logic [CSA_W-1:0]  cs_wr_addr,
    input  logic [7:0]        cs_wr_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data
);

    typedef struct packed {
        logic             cfg_pcm;
        logic [CNT_W-1:0] cfg_cnt;
        logic             o_valid;
        logic             o_pcm;
        word_t            o_data;
    } state_t;

    state_t st_d, st_q;

    logic [CS_BITS-1:0] cs_flat;
    logic [CH_W-1:0]    ch_idx;
    logic [FR_W-1:0]    frame_idx;
    word_t              packed_word;
    logic               accept;
    logic               idle;
    logic [CNT_W-1:0]   cnt_clamped;

    aud_cs_regfile #(.CS_BYTES(CS_BYTES)) u_cs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cs_wr_en),
        .wr_addr (cs_wr_addr),
        .wr_data (cs_wr_data),
        .cs_flat (cs_flat)
    );

    aud_seq_counter #(.MAX_CH(MAX_CH), .BLOCK_LEN(BLOCK_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .step      (accept),
        .ch_count  (st_q.cfg_cnt),
        .ch_idx    (ch_idx),
        .frame_idx (frame_idx)
    );

    aud_subframe_packer #(
        .MAX_CH(MAX_CH), .BLOCK_LEN(BLOCK_LEN), .CS_BYTES(CS_BYTES)
    ) u_pack (
        .pcm       (st_q.cfg_pcm),
        .in_word   (in_data),
        .ch_idx    (ch_idx),
        .frame_idx (frame_idx),
        .cs_flat   (cs_flat),
        .out_word  (packed_word)
    );

    always_comb begin
        in_ready = !clr && (!st_q.o_valid || out_ready);
        accept   = in_valid && in_ready;
        idle     = !accept && (ch_idx == '0);

        if (chan_cnt < CNT_W'(MIN_CH))      cnt_clamped = CNT_W'(MIN_CH);
        else if (chan_cnt > CNT_W'(MAX_CH)) cnt_clamped = CNT_W'(MAX_CH);
        else                                cnt_clamped = chan_cnt;

        st_d = st_q;
        if (idle) begin
            st_d.cfg_pcm = mode_pcm;
            st_d.cfg_cnt = cnt_clamped;
        end
        if (accept) begin
            st_d.o_valid = 1'b1;
            st_d.o_pcm   = st_q.cfg_pcm;
            st_d.o_data  = packed_word;
        end else if (out_ready) begin
            st_d.o_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cfg_cnt <= CNT_W'(MIN_CH);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_valid;
    assign out_data  = st_q.o_data;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));   // R11

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.o_pcm) |-> (^out_data[BIT_PAR:0] == 1'b0));    // R6

    AST_PCM_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.o_pcm) |->
        (out_data[31:29] == 3'b000 && out_data[25:24] == 2'b00));          // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_idx != '0) |=> ($stable(st_q.cfg_pcm) && $stable(st_q.cfg_cnt))); // R10

endmodule

// File: tb/sim_aud_subframe_fmt.sv
module sim_aud_subframe_fmt;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        mode_pcm = 1'b0;
    logic [3:0]  chan_cnt = 4'd2;
    logic        cs_wr_en = 1'b0;
    logic [1:0]  cs_wr_addr = '0;
    logic [7:0]  cs_wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic [7:0] cs_m [4];
    int m_ch = 0, m_fr = 0, m_cnt = 2;
    logic m_pcm = 1'b0;

    localparam logic [31:0] VEC_IN  [0:5] = '{32'hF1234568, 32'h0ABCDEF4, 32'h80000002,
                                             32'hFFFFFFFF, 32'h00000000, 32'h7654321A};
    localparam logic [31:0] VEC_EXP [0:5] = '{32'h1F123456, 32'h00ABCDEF, 32'h08000000,
                                             32'h1FFFFFFF, 32'h00000000, 32'h17654321};

    always #(CLK_P/2) clk = ~clk;

    aud_subframe_fmt u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode_pcm(mode_pcm), .chan_cnt(chan_cnt),
        .cs_wr_en(cs_wr_en), .cs_wr_addr(cs_wr_addr), .cs_wr_data(cs_wr_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clamp_cnt(input logic [3:0] c);
        if (c < 4'd2) return 2;
        if (c > 4'd8) return 8;
        return int'(c);
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] w);
        logic [31:0] r;
        logic c;
        if (!m_pcm) return {3'b000, w[3], w[31:4]};
        if (m_fr >= 20 && m_fr <= 23)      c = 1'((m_ch + 1) >> (m_fr - 20));
        else if (m_fr < 32)                c = cs_m[m_fr / 8][m_fr % 8];
        else                               c = 1'b0;
        r = {3'b000, (m_ch == 0 && m_fr == 0), 1'b0, c, 2'b00, w[23:0]};
        r[27] = ^r[26:0];
        return r;
    endfunction

    function automatic void advance();
        m_ch++;
        if (m_ch >= m_cnt) begin
            m_ch = 0;
            m_fr = (m_fr == 191) ? 0 : m_fr + 1;
        end
    endfunction

    task automatic xfer(input string req, input logic [31:0] w);
        logic [31:0] e;
        e = expect_word(w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk(req, out_data, e);
        advance();
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        #1;
        chk("R9 in_ready low in clear", 32'(in_ready), 32'd0);
        @(negedge clk);
        clr = 1'b0;
        m_ch = 0; m_fr = 0;
        m_cnt = clamp_cnt(chan_cnt);
        m_pcm = mode_pcm;
    endtask

    task automatic cs_write(input int a, input logic [7:0] d);
        @(negedge clk);
        cs_wr_en = 1'b1; cs_wr_addr = 2'(a); cs_wr_data = d;
        @(negedge clk);
        cs_wr_en = 1'b0;
        cs_m[a] = d;
    endtask

    function automatic logic [31:0] pat(input int k);
        return {8'(k * 37 + 8'hC3), 24'(k * 24'h01F3A7 + 24'h00005A)};
    endfunction

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) cs_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset out_valid", 32'(out_valid), 32'd0);
        chk("R11 reset in_ready", 32'(in_ready), 32'd1);

        // R1: subframe repack table
        mode_pcm = 1'b0; chan_cnt = 4'd2;
        do_clear();
        for (int i = 0; i < 6; i++) begin
            chk("R1 table model", expect_word(VEC_IN[i]), VEC_EXP[i]);
            xfer("R1 subframe repack", VEC_IN[i]);
        end

        // R12 reset status bytes are zero; R2/R3/R4/R5/R6 in PCM mode
        mode_pcm = 1'b1;
        do_clear();
        for (int k = 0; k < 2 * 26; k++) xfer("R12 R3 zero status after reset", pat(k));

        cs_write(0, 8'hA5); cs_write(1, 8'h3C); cs_write(2, 8'h0F); cs_write(3, 8'h81);
        do_clear();
        // R7: 193 frames of 2 channels, block start returns after wrap
        for (int k = 0; k < 2 * 193; k++) xfer("R2 R3 R4 R5 R6 R7 pcm block", pat(k + 100));

        // R8: clamp to 8 and to 2, R4 channel numbers for all 8 channels
        chan_cnt = 4'd12;
        do_clear();
        for (int k = 0; k < 8 * 25; k++) xfer("R8 R4 eight channels clamp", pat(k + 7));
        chan_cnt = 4'd1;
        do_clear();
        for (int k = 0; k < 6; k++) xfer("R8 clamp to two", pat(k + 3));

        // R9: clear mid-frame
        chan_cnt = 4'd3;
        do_clear();
        for (int k = 0; k < 5; k++) xfer("R9 pre-clear", pat(k));
        do_clear();
        xfer("R9 R5 restart at block start", 32'h00ABCDEF);

        // R10: mode and count change mid-frame apply at next frame start
        chan_cnt = 4'd4; mode_pcm = 1'b1;
        do_clear();
        xfer("R10 ch0 pcm", pat(50));
        mode_pcm = 1'b0; chan_cnt = 4'd2;
        for (int k = 0; k < 3; k++) xfer("R10 old mode held mid-frame", pat(51 + k));
        m_pcm = 1'b0; m_cnt = 2;
        for (int k = 0; k < 4; k++) xfer("R10 new mode at frame start", pat(60 + k));

        // R11: backpressure
        mode_pcm = 1'b1; chan_cnt = 4'd2;
        do_clear();
        begin
            logic [31:0] ea, eb;
            ea = expect_word(32'h11223344);
            @(negedge clk);
            out_ready = 1'b0; in_valid = 1'b1; in_data = 32'h11223344;
            @(negedge clk);
            advance();
            eb = expect_word(32'h55667788);
            chk("R11 first word out", out_data, ea);
            in_data = 32'h55667788;
            #1;
            chk("R11 in_ready low when stalled", 32'(in_ready), 32'd0);
            @(negedge clk);
            chk("R11 data held", out_data, ea);
            chk("R11 valid held", 32'(out_valid), 32'd1);
            out_ready = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            advance();
            chk("R11 second word after release", out_data, eb);
            @(negedge clk);
            chk("R11 drained", 32'(out_valid), 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule